// File: doc/BRIEF.md
# Triangle-Wave Dither Offset Generator

This block generates a digital offset word shaped as a symmetric triangle. It serves spread-spectrum clocking: a digitally controlled oscillator or a fractional divider subtracts the word from its nominal setting, so the produced frequency sweeps slowly below nominal and the emitted energy is spread out. The offset is unsigned and never negative, so the frequency can only fall below nominal and never rise above it. One full triangle, rising and then falling, takes exactly 4096 master clock cycles. The dither repetition rate is therefore the master clock divided by 4096.

A span-select input chooses the peak. With the input at 0, the wide span is used: full scale is 2047 codes, which stands for a 4% deviation. With the input at 1, the narrow span is used: full scale is 1023 codes, which stands for a 2% deviation. A new span value only takes effect at a triangle boundary, where the offset is zero. This keeps the sweep from jumping.

Dither runs only while the enable input is high. While the enable is low, the offset is held at zero and the sweep position returns to the start. The next enable therefore begins at the undithered frequency. Both control inputs pass through a synchronizer before use. The offset is a level that the consumer reads every cycle. It has no valid/ready handshake and no back-pressure, because no data is ever held back or lost.

Top module: `dither_offset_gen`

## Requirements
- R1: While reset is asserted, offset_o is 0.
- R2: While the synchronized enable is low, offset_o is 0 on the following cycle.
- R2: While the synchronized enable is low, the sweep position returns to the start.
- R3: While the block stays enabled, the offset waveform repeats every 4096 master cycles.
- R4: While enabled, consecutive offset values differ by at most one code step. The offset rises for 2048 cycles and then falls for 2048 cycles.
- R5: With span_narrow_i = 0 (wide span, 4%), the peak offset is 2047.
- R6: With span_narrow_i = 1 (narrow span, 2%), the offset never exceeds 1023, and the peak offset is 1023.
- R7: The offset is unsigned and is zero at the start of each period, so the deviation is one-sided, below nominal only.
- R8: After dith_en_i rises, offset_o first becomes 1 at SYNC_STAGES+2 rising clock edges after the first edge that samples the high level. For the default of 2, that is 4 edges.
- R9: A change of span_narrow_i during a sweep does not alter the current period. The new span is adopted only at a period boundary, where the offset is 0.
- R10: When the enable is deasserted and then asserted again, the sweep restarts from offset 0 with the same latency as R8. It uses the span that is present at the input while the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dith_en_i | input | 1 | Dither enable, asynchronous level |
| span_narrow_i | input | 1 | 1 selects the 2% span, 0 selects the 4% span |
| offset_o | output | 11 | Unsigned frequency-lowering offset, one value per cycle |

## Verification
The properties assume that both control inputs are quasi-static levels. They also assume that span changes matter to the waveform only through the synchronized and latched copy. The step-size and span-cap properties therefore watch the internal synchronized enable and the latched span, not the raw pins. The stimulus changes the inputs only at falling clock edges. It holds each level for many cycles, well beyond the synchronizer depth. It switches the span both in the middle of a sweep and while the block is disabled, so that the boundary rule is exercised on both paths.

// File: rtl/dither_pkg.sv
package dither_pkg;
  typedef enum logic {
    SPAN_WIDE   = 1'b0,
    SPAN_NARROW = 1'b1
  } span_e;
endpackage

// File: rtl/dith_sync.sv
module dith_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dith_phase.sv
module dith_phase
  import dither_pkg::*;
#(
  parameter int PH_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  span_e           span_in,
  output logic [PH_W-1:0] phase,
  output span_e           span_q
);
  localparam logic [PH_W-1:0] LAST = '1;

  logic at_end;
  assign at_end = (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (!run) phase <= '0;
    else          phase <= phase + 1'b1;
  end

  // span is adopted only while idle or on the last step of a period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 span_q <= SPAN_WIDE;
    else if (!run || at_end)    span_q <= span_in;
  end
endmodule

// File: rtl/dith_shape.sv
module dith_shape
  import dither_pkg::*;
#(
  parameter int PH_W  = 12,
  parameter int OFS_W = PH_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PH_W-1:0]  phase,
  input  span_e            span,
  output logic [OFS_W-1:0] offset
);
  logic             falling;
  logic [OFS_W-1:0] ramp;
  logic [OFS_W-1:0] folded;
  logic [OFS_W-1:0] scaled;

  assign falling = phase[PH_W-1];
  assign ramp    = phase[OFS_W-1:0];
  assign folded  = falling ? ~ramp : ramp;
  assign scaled  = (span == SPAN_NARROW) ? (folded >> 1) : folded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    offset <= '0;
    else if (!run) offset <= '0;
    else           offset <= scaled;
  end
endmodule

// File: rtl/dither_offset_gen.sv
module dither_offset_gen
  import dither_pkg::*;
#(
  parameter int HALF_BITS   = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dith_en_i,
  input  logic                 span_narrow_i,
  output logic [HALF_BITS-1:0] offset_o
);
  localparam int PH_W  = HALF_BITS + 1;
  localparam int OFS_W = HALF_BITS;

  logic [1:0]      ctl_sync;
  logic            en_sync;
  span_e           span_sync;
  span_e           span_q;
  logic [PH_W-1:0] phase;

  dith_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dith_en_i, span_narrow_i}),
    .q     (ctl_sync)
  );

  assign en_sync   = ctl_sync[1];
  assign span_sync = span_e'(ctl_sync[0]);

  dith_phase #(.PH_W(PH_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_sync),
    .span_in (span_sync),
    .phase   (phase),
    .span_q  (span_q)
  );

  dith_shape #(.PH_W(PH_W), .OFS_W(OFS_W)) u_shape (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (en_sync),
    .phase  (phase),
    .span   (span_q),
    .offset (offset_o)
  );
endmodule

// File: rtl/dither_offset_chk.sv
module dither_offset_chk #(
  parameter int OFS_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             narrow,
  input logic [OFS_W-1:0] offset
);
  localparam logic [OFS_W-1:0] HALF_MAX = {1'b0, {(OFS_W-1){1'b1}}};

  always @(negedge clk) begin
    if (!rst_n) assert_reset_zero_R1: assert (offset == '0);
  end

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> offset == '0);

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |=>
      (offset == $past(offset)) ||
      ({1'b0, offset} == {1'b0, $past(offset)} + 1'b1) ||
      ({1'b0, $past(offset)} == {1'b0, offset} + 1'b1));

  assert_narrow_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> offset <= HALF_MAX);

  assert_span_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(narrow) |-> offset == '0);
endmodule

bind dither_offset_gen dither_offset_chk #(.OFS_W(OFS_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (en_sync),
  .narrow (span_q),
  .offset (offset_o)
);

// File: tb/dither_offset_gen_test.sv
module dither_offset_gen_test;
  localparam int SYNC = 2;
  localparam int PERIOD = 4096;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic        narrow = 0;
  logic [10:0] offset;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  dither_offset_gen #(.HALF_BITS(11), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .dith_en_i(en),
    .span_narrow_i(narrow), .offset_o(offset)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  bit en_hist[$];
  bit nw_hist[$];
  int pos = 0;
  bit span_m = 0;
  int expv = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_hist.delete(); nw_hist.delete();
      pos = 0; span_m = 0; expv = 0;
    end else begin
      bit cur_en, cur_nw;
      int tri_v;
      cur_en = (en_hist.size() == SYNC) ? en_hist[0] : 1'b0;
      cur_nw = (nw_hist.size() == SYNC) ? nw_hist[0] : 1'b0;
      en_hist.push_back(en); nw_hist.push_back(narrow);
      if (en_hist.size() > SYNC) begin
        void'(en_hist.pop_front()); void'(nw_hist.pop_front());
      end
      if (!cur_en) begin
        expv = 0; pos = 0; span_m = cur_nw;
      end else begin
        tri_v = (pos < PERIOD/2) ? pos : (PERIOD - 1 - pos);
        expv = span_m ? (tri_v / 2) : tri_v;
        if (pos == PERIOD - 1) span_m = cur_nw;
        pos = (pos + 1) % PERIOD;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // per-cycle comparison and waveform statistics
  string phase_tag = "R2";
  int peak_seen = 0;
  int cyc = 0;
  int prev = 0;
  int last_start = -1;
  int last_gap = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      check(int'(offset) == expv, phase_tag, offset, expv);
      if (int'(offset) > peak_seen) peak_seen = offset;
      if (prev == 0 && offset == 1) begin
        if (last_start >= 0) last_gap = cyc - last_start;
        last_start = cyc;
      end
      prev = offset;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges_to_one(output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (offset != 1 && n < 50);
  endtask

  initial begin
    int lat;
    cycles(5);
    check(offset == 0, "R1 reset value", offset, 0);
    rst_n = 1;

    phase_tag = "R2";
    cycles(20);
    check(peak_seen == 0, "R2 idle peak", peak_seen, 0);

    // R8 enable latency, wide span
    phase_tag = "R4 wide sweep";
    en = 1;
    edges_to_one(lat);
    check(lat == SYNC + 2, "R8 enable latency", lat, SYNC + 2);

    peak_seen = 0;
    cycles(2 * PERIOD + 10);
    check(peak_seen == 2047, "R5 wide peak", peak_seen, 2047);
    check(last_gap == PERIOD, "R3 period wide", last_gap, PERIOD);

    // R9 mid-sweep span change keeps current period
    phase_tag = "R9 span switch";
    while (offset != 1024) @(negedge clk);
    narrow = 1;
    peak_seen = 0;
    cycles(1500);
    check(peak_seen == 2047, "R9 old span kept", peak_seen, 2047);

    phase_tag = "R6 narrow sweep";
    cycles(PERIOD);
    peak_seen = 0;
    cycles(PERIOD + 10);
    check(peak_seen == 1023, "R6 narrow peak", peak_seen, 1023);
    check(last_gap == PERIOD, "R3 period narrow", last_gap, PERIOD);

    // R10 disable mid-sweep, change span while idle, re-enable
    phase_tag = "R2 disabled";
    cycles(700);
    en = 0;
    cycles(SYNC + 3);
    check(offset == 0, "R2 offset after disable", offset, 0);
    narrow = 0;
    cycles(30);
    check(offset == 0, "R2 held zero", offset, 0);

    phase_tag = "R10 restart";
    en = 1;
    edges_to_one(lat);
    check(lat == SYNC + 2, "R10 restart latency", lat, SYNC + 2);
    peak_seen = 0;
    cycles(2100);
    check(peak_seen == 2047, "R10 idle span adopted", peak_seen, 2047);
    cycles(PERIOD - 2100 - 10);
    check(offset < 16, "R7 near boundary low", offset, 0);

    cycles(20);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule